// File: doc/BRIEF.md
# Conditional Flow and Call Sequencer

This block works out where a small 16-bit processor fetches next after a control-transfer instruction. It also works out how the chosen stack register moves when that instruction uses the stack. Jumps and branches are resolved in one cycle. The condition is tested with a three-bit care mask and a three-bit polarity over the carry, zero and negative flags. The target is either the immediate word itself or that word added to the program counter.

Calls, returns, pushes and pops each need one memory access. The block issues that access through a simple request/acknowledge port and holds it until memory answers. It then reports the new program counter, the new stack pointer and any loaded register value together with a one-cycle `done` pulse. The stack grows downward by one word per entry: entries are stored after a pre-decrement and removed with a post-increment. The register file, the ALU and instruction fetch stay outside the block; the caller presents the stack register's current value and writes back the values the block hands out.

Top module: `flowseq_unit`

## Requirements
- R1: A jump or branch is taken exactly when `(flags & condMask) == condPol`. In all three fields bit 2 is carry, bit 1 is zero and bit 0 is negative, so mask 000 with polarity 000 is always taken.
- R2: Opcode 000010 (jump), when taken, gives `done` and `pcLoad` high with `pcNext == immIn` in the cycle after `start`.
- R3: Opcode 000011 (branch), when taken, gives `pcNext == pcIn + immIn` modulo 2^W in the cycle after `start`.
- R4: A jump or branch that is not taken still pulses `done` and `pcLoad`, with `pcNext == pcIn`.
- R5: Opcodes 010000 (absolute call) and 010001 (relative call) issue a write of `pcIn` to address `spIn - 2`. After a clean acknowledge they load `pcNext` with `immIn` or `pcIn + immIn` respectively, and write `spNext == spIn - 2`.
- R6: Opcode 010010 (return) issues a read at `spIn`. After a clean acknowledge it loads `pcNext` with the read data and writes `spNext == spIn + 2`.
- R7: Opcode 010100 (push) writes `srcData` at `spIn - 2`. After a clean acknowledge it writes `spNext == spIn - 2` and leaves `pcLoad` and `regWrite` low.
- R8: Opcode 010101 (pop) reads at `spIn`. After a clean acknowledge it raises `regWrite` with `regWdata` equal to the read data and writes `spNext == spIn + 2`, with `pcLoad` low.
- R9: While `memReq` is high and `memAck` is low, the request's address, direction and write data hold steady. `done` rises in the cycle after the acknowledge and never while a request is open.
- R10: An acknowledge that comes with `memErr` gives `done` together with `busErr`, and leaves `spWrite`, `pcLoad` and `regWrite` low.
- R11: A `start` with any other opcode, or a `start` during an open memory access, has no effect: it produces no `done` and no new request.
- R12: After reset, `done`, `pcLoad`, `spWrite`, `regWrite`, `busErr` and `memReq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction presented for one cycle |
| opcode | input | 6 | Instruction class field |
| condMask | input | 3 | Flag care mask {carry, zero, negative} |
| condPol | input | 3 | Required flag values {carry, zero, negative} |
| flags | input | 3 | Current flags {carry, zero, negative} |
| pcIn | input | W | Address of the word after the immediate |
| immIn | input | W | Immediate word |
| spIn | input | W | Current value of the chosen stack register |
| srcData | input | W | Source register value for push |
| memReq | output | 1 | Memory access open |
| memWrite | output | 1 | Access is a write |
| memAddr | output | W | Access address |
| memWdata | output | W | Write data |
| memAck | input | 1 | Memory completes the access |
| memErr | input | 1 | Access failed (valid with memAck) |
| memRdata | input | W | Read data (valid with memAck) |
| done | output | 1 | Instruction finished, one cycle |
| pcLoad | output | 1 | Load pcNext into the program counter |
| pcNext | output | W | New program counter |
| spWrite | output | 1 | Write spNext into the stack register |
| spNext | output | W | New stack register value |
| regWrite | output | 1 | Write regWdata into the pop destination |
| regWdata | output | W | Value popped from the stack |
| busErr | output | 1 | The memory access ended in error |

## Verification
The bench builds the block with the default width of 16, so the stack step is 2 bytes. It sweeps all 512 mask, polarity and flag combinations for both jumps and branches, which exercises every condition case. Stack operations run with stack values at zero and near the top of the address space, so the wraparound of the pre-decrement and post-increment is checked. Acknowledge delays range from zero to several cycles, which tests that the request holds steady and that a `start` arriving mid-access is ignored.

// File: rtl/flowseq_pkg.sv
package flowseq_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_JUMP, OP_BRANCH, OP_CALLA, OP_CALLR, OP_RET, OP_PUSH, OP_POP
  } opKind_t;

  typedef struct packed {
    logic    flowNow;   // resolve jump/branch this cycle
    logic    capture;   // latch operands and open a memory access
    logic    finish;    // clean acknowledge seen
    logic    fault;     // acknowledge with error seen
    opKind_t kind;      // decoded class of the presented instruction
  } seqStrobes_t;

  function automatic opKind_t decodeOp(input logic [5:0] op);
    case (op)
      6'b000010: decodeOp = OP_JUMP;
      6'b000011: decodeOp = OP_BRANCH;
      6'b010000: decodeOp = OP_CALLA;
      6'b010001: decodeOp = OP_CALLR;
      6'b010010: decodeOp = OP_RET;
      6'b010100: decodeOp = OP_PUSH;
      6'b010101: decodeOp = OP_POP;
      default:   decodeOp = OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/flowseq_ctrl.sv
module flowseq_ctrl
  import flowseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [5:0]  opcode,
  input  logic        memAck,
  input  logic        memErr,
  output seqStrobes_t strobes,
  output logic        memReq
);

  typedef enum logic {S_IDLE, S_WAIT} state_t;
  state_t state;
  opKind_t kind;
  logic accept;
  logic isFlow;

  always_comb begin
    kind   = decodeOp(opcode);
    accept = (state == S_IDLE) && start && (kind != OP_NONE);
    isFlow = (kind == OP_JUMP) || (kind == OP_BRANCH);
    strobes.kind    = kind;
    strobes.flowNow = accept && isFlow;
    strobes.capture = accept && !isFlow;
    strobes.finish  = (state == S_WAIT) && memAck && !memErr;
    strobes.fault   = (state == S_WAIT) && memAck && memErr;
    memReq          = (state == S_WAIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (strobes.capture) state <= S_WAIT;
        S_WAIT:  if (memAck) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flowseq_dp.sv
module flowseq_dp
  import flowseq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t strobes,
  input  logic [2:0]  condMask,
  input  logic [2:0]  condPol,
  input  logic [2:0]  flags,
  input  logic [W-1:0] pcIn,
  input  logic [W-1:0] immIn,
  input  logic [W-1:0] spIn,
  input  logic [W-1:0] srcData,
  input  logic [W-1:0] memRdata,
  output logic        memWrite,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWdata,
  output logic        done,
  output logic        pcLoad,
  output logic [W-1:0] pcNext,
  output logic        spWrite,
  output logic [W-1:0] spNext,
  output logic        regWrite,
  output logic [W-1:0] regWdata,
  output logic        busErr
);

  localparam int STEP_BYTES = W / 8;
  localparam logic [W-1:0] STEP = W'(STEP_BYTES);
  localparam int NFLAGS = 3;

  logic [NFLAGS-1:0] bitOk;
  logic taken;
  logic pushesStack;
  logic [W-1:0] spDec, spInc, relTarget, absOrRel;
  opKind_t kindReg;
  logic [W-1:0] tgtReg;

  // per-flag compare: a flag matches when its masked value equals the polarity bit
  for (genvar i = 0; i < NFLAGS; i++) begin : g_cond
    assign bitOk[i] = ((flags[i] & condMask[i]) == condPol[i]);
  end

  always_comb begin
    taken       = &bitOk;
    spDec       = spIn - STEP;
    spInc       = spIn + STEP;
    relTarget   = pcIn + immIn;
    pushesStack = (strobes.kind == OP_CALLA) || (strobes.kind == OP_CALLR) ||
                  (strobes.kind == OP_PUSH);
    absOrRel    = ((strobes.kind == OP_JUMP) || (strobes.kind == OP_CALLA)) ? immIn : relTarget;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindReg  <= OP_NONE;
      tgtReg   <= '0;
      memWrite <= 1'b0;
      memAddr  <= '0;
      memWdata <= '0;
      done     <= 1'b0;
      pcLoad   <= 1'b0;
      pcNext   <= '0;
      spWrite  <= 1'b0;
      spNext   <= '0;
      regWrite <= 1'b0;
      regWdata <= '0;
      busErr   <= 1'b0;
    end else begin
      done     <= 1'b0;
      pcLoad   <= 1'b0;
      spWrite  <= 1'b0;
      regWrite <= 1'b0;
      busErr   <= 1'b0;

      if (strobes.flowNow) begin
        done   <= 1'b1;
        pcLoad <= 1'b1;
        pcNext <= taken ? absOrRel : pcIn;
      end

      if (strobes.capture) begin
        kindReg  <= strobes.kind;
        tgtReg   <= absOrRel;
        memWrite <= pushesStack;
        memAddr  <= pushesStack ? spDec : spIn;
        memWdata <= (strobes.kind == OP_PUSH) ? srcData : pcIn;
        spNext   <= pushesStack ? spDec : spInc;
      end

      if (strobes.finish) begin
        done    <= 1'b1;
        spWrite <= 1'b1;
        case (kindReg)
          OP_CALLA, OP_CALLR: begin
            pcLoad <= 1'b1;
            pcNext <= tgtReg;
          end
          OP_RET: begin
            pcLoad <= 1'b1;
            pcNext <= memRdata;
          end
          OP_POP: begin
            regWrite <= 1'b1;
            regWdata <= memRdata;
          end
          default: ;
        endcase
      end

      if (strobes.fault) begin
        done   <= 1'b1;
        busErr <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flowseq_unit.sv
module flowseq_unit
  import flowseq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [5:0]   opcode,
  input  logic [2:0]   condMask,
  input  logic [2:0]   condPol,
  input  logic [2:0]   flags,
  input  logic [W-1:0] pcIn,
  input  logic [W-1:0] immIn,
  input  logic [W-1:0] spIn,
  input  logic [W-1:0] srcData,
  output logic         memReq,
  output logic         memWrite,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWdata,
  input  logic         memAck,
  input  logic         memErr,
  input  logic [W-1:0] memRdata,
  output logic         done,
  output logic         pcLoad,
  output logic [W-1:0] pcNext,
  output logic         spWrite,
  output logic [W-1:0] spNext,
  output logic         regWrite,
  output logic [W-1:0] regWdata,
  output logic         busErr
);

  seqStrobes_t strobes;

  flowseq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opcode  (opcode),
    .memAck  (memAck),
    .memErr  (memErr),
    .strobes (strobes),
    .memReq  (memReq)
  );

  flowseq_dp #(.W(W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .condMask (condMask),
    .condPol  (condPol),
    .flags    (flags),
    .pcIn     (pcIn),
    .immIn    (immIn),
    .spIn     (spIn),
    .srcData  (srcData),
    .memRdata (memRdata),
    .memWrite (memWrite),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .done     (done),
    .pcLoad   (pcLoad),
    .pcNext   (pcNext),
    .spWrite  (spWrite),
    .spNext   (spNext),
    .regWrite (regWrite),
    .regWdata (regWdata),
    .busErr   (busErr)
  );

endmodule

// File: rtl/flowseq_checker.sv
module flowseq_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         memReq,
  input logic         memWrite,
  input logic [W-1:0] memAddr,
  input logic [W-1:0] memWdata,
  input logic         memAck,
  input logic         done,
  input logic         pcLoad,
  input logic         spWrite,
  input logic         regWrite,
  input logic         busErr
);

  // R9: an open request does not move until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite) && $stable(memWdata)));

  // R9: completion never overlaps an open request
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !done);

  // R10: a failed access writes nothing back
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (done && !spWrite && !pcLoad && !regWrite));

  // R5: write-back strobes only appear with completion
  p_wb_with_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    (spWrite || pcLoad || regWrite) |-> done);

  // R8: a pop never also redirects the program counter
  p_pop_no_pc_r8: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |-> (!pcLoad && spWrite));

  // R9: completion of a memory op follows its acknowledge
  p_ack_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> (done && !memReq));

endmodule

bind flowseq_unit flowseq_checker #(.W(W)) u_flowseq_checker (
  .clk      (clk),
  .rstN     (rstN),
  .memReq   (memReq),
  .memWrite (memWrite),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memAck   (memAck),
  .done     (done),
  .pcLoad   (pcLoad),
  .spWrite  (spWrite),
  .regWrite (regWrite),
  .busErr   (busErr)
);

// File: tb/flowseq_unit_bench.sv
module flowseq_unit_bench;

  localparam int W = 16;
  localparam real HALF = 2.5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [5:0] opcode = '0;
  logic [2:0] condMask = '0, condPol = '0, flags = '0;
  logic [W-1:0] pcIn = '0, immIn = '0, spIn = '0, srcData = '0, memRdata = '0;
  logic memAck = 1'b0, memErr = 1'b0;
  logic memReq, memWrite, done, pcLoad, spWrite, regWrite, busErr;
  logic [W-1:0] memAddr, memWdata, pcNext, spNext, regWdata;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(HALF) clk = ~clk;

  flowseq_unit #(.W(W)) u_flowseq_unit (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .condMask(condMask), .condPol(condPol), .flags(flags),
    .pcIn(pcIn), .immIn(immIn), .spIn(spIn), .srcData(srcData),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memErr(memErr), .memRdata(memRdata),
    .done(done), .pcLoad(pcLoad), .pcNext(pcNext),
    .spWrite(spWrite), .spNext(spNext), .regWrite(regWrite), .regWdata(regWdata),
    .busErr(busErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // present an instruction at a falling edge; return at the next falling edge
  task automatic issue(input logic [5:0] op);
    opcode = op;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
  endtask

  // acknowledge after 'delay' idle cycles while checking the request holds
  task automatic ackAfter(input int delay, input logic err, input logic [W-1:0] rd,
                          input logic [W-1:0] expAddr, input logic expWr);
    for (int k = 0; k < delay; k++) begin
      @(negedge clk);
      chk("R9 hold req", {31'd0, memReq}, 32'd1);
      chk("R9 hold addr", {16'd0, memAddr}, {16'd0, expAddr});
      chk("R9 hold dir", {31'd0, memWrite}, {31'd0, expWr});
      chk("R9 no early done", {31'd0, done}, 32'd0);
    end
    memAck = 1'b1; memErr = err; memRdata = rd;
    @(negedge clk);
    memAck = 1'b0; memErr = 1'b0;
  endtask

  initial begin
    #(HALF * 2.0 * 200000.0);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] expPc, sp;
    bit tk;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 done", {31'd0, done}, 32'd0);
    chk("R12 pcLoad", {31'd0, pcLoad}, 32'd0);
    chk("R12 spWrite", {31'd0, spWrite}, 32'd0);
    chk("R12 regWrite", {31'd0, regWrite}, 32'd0);
    chk("R12 busErr", {31'd0, busErr}, 32'd0);
    chk("R12 memReq", {31'd0, memReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1-style sweep over every mask/polarity/flag combination for jump (R2) and branch (R3)
    for (int b = 0; b < 2; b++) begin
      for (int m = 0; m < 8; m++) begin
        for (int p = 0; p < 8; p++) begin
          for (int f = 0; f < 8; f++) begin
            condMask = 3'(m); condPol = 3'(p); flags = 3'(f);
            pcIn  = 16'(16'hFF00 + m * 37 + f * 3);
            immIn = 16'(16'h0150 + p * 211 + f);
            tk = ((f & m) == p);
            if (!tk)      expPc = pcIn;
            else if (b == 0) expPc = immIn;
            else          expPc = pcIn + immIn;
            issue(b == 0 ? 6'b000010 : 6'b000011);
            chk("R1 done", {31'd0, done}, 32'd1);
            chk("R4 pcLoad", {31'd0, pcLoad}, 32'd1);
            if (!tk)      chk("R4 not taken pc", {16'd0, pcNext}, {16'd0, expPc});
            else if (b == 0) chk("R2 jump pc", {16'd0, pcNext}, {16'd0, expPc});
            else          chk("R3 branch pc", {16'd0, pcNext}, {16'd0, expPc});
            chk("R1 no stack write", {31'd0, spWrite}, 32'd0);
          end
        end
      end
    end

    // stack operations at several stack values and acknowledge delays
    for (int s = 0; s < 4; s++) begin
      sp = (s == 0) ? 16'h0000 : (s == 1) ? 16'hFFFE : (s == 2) ? 16'h8000 : 16'h1236;
      for (int d = 0; d < 4; d++) begin
        spIn = sp; pcIn = 16'h4000 + 16'(s * 8 + d); immIn = 16'hC010 + 16'(d);
        srcData = 16'hA5A0 + 16'(s);
        // R5: absolute and relative call
        for (int r = 0; r < 2; r++) begin
          issue(r == 0 ? 6'b010000 : 6'b010001);
          chk("R5 req", {31'd0, memReq}, 32'd1);
          chk("R5 write", {31'd0, memWrite}, 32'd1);
          chk("R5 addr", {16'd0, memAddr}, {16'd0, 16'(sp - 16'd2)});
          chk("R5 data", {16'd0, memWdata}, {16'd0, pcIn});
          ackAfter(d, 1'b0, 16'h0, 16'(sp - 16'd2), 1'b1);
          chk("R5 done", {31'd0, done}, 32'd1);
          chk("R5 pcLoad", {31'd0, pcLoad}, 32'd1);
          chk("R5 target", {16'd0, pcNext}, {16'd0, (r == 0) ? immIn : 16'(pcIn + immIn)});
          chk("R5 spWrite", {31'd0, spWrite}, 32'd1);
          chk("R5 spNext", {16'd0, spNext}, {16'd0, 16'(sp - 16'd2)});
        end
        // R6: return
        issue(6'b010010);
        chk("R6 read", {31'd0, memWrite}, 32'd0);
        chk("R6 addr", {16'd0, memAddr}, {16'd0, sp});
        ackAfter(d, 1'b0, 16'h5A5A ^ 16'(s * 4 + d), sp, 1'b0);
        chk("R6 pc", {16'd0, pcNext}, {16'd0, 16'h5A5A ^ 16'(s * 4 + d)});
        chk("R6 pcLoad", {31'd0, pcLoad}, 32'd1);
        chk("R6 spNext", {16'd0, spNext}, {16'd0, 16'(sp + 16'd2)});
        chk("R6 spWrite", {31'd0, spWrite}, 32'd1);
        // R7: push
        issue(6'b010100);
        chk("R7 write", {31'd0, memWrite}, 32'd1);
        chk("R7 addr", {16'd0, memAddr}, {16'd0, 16'(sp - 16'd2)});
        chk("R7 data", {16'd0, memWdata}, {16'd0, srcData});
        ackAfter(d, 1'b0, 16'h0, 16'(sp - 16'd2), 1'b1);
        chk("R7 spNext", {16'd0, spNext}, {16'd0, 16'(sp - 16'd2)});
        chk("R7 no pc/reg", {30'd0, pcLoad, regWrite}, 32'd0);
        // R8: pop
        issue(6'b010101);
        chk("R8 addr", {16'd0, memAddr}, {16'd0, sp});
        ackAfter(d, 1'b0, 16'h3C00 + 16'(d), sp, 1'b0);
        chk("R8 regWrite", {31'd0, regWrite}, 32'd1);
        chk("R8 regWdata", {16'd0, regWdata}, {16'd0, 16'h3C00 + 16'(d)});
        chk("R8 spNext", {16'd0, spNext}, {16'd0, 16'(sp + 16'd2)});
        chk("R8 no pc", {31'd0, pcLoad}, 32'd0);
      end
    end

    // R10: error acknowledges for each memory class
    spIn = 16'h2000;
    for (int o = 0; o < 4; o++) begin
      issue(o == 0 ? 6'b010000 : o == 1 ? 6'b010010 : o == 2 ? 6'b010100 : 6'b010101);
      ackAfter(1, 1'b1, 16'hDEAD, (o == 0 || o == 2) ? 16'h1FFE : 16'h2000, (o == 0 || o == 2));
      chk("R10 done", {31'd0, done}, 32'd1);
      chk("R10 busErr", {31'd0, busErr}, 32'd1);
      chk("R10 quiet", {29'd0, spWrite, pcLoad, regWrite}, 32'd0);
    end

    // R11: unused opcodes are ignored
    for (int u = 0; u < 64; u++) begin
      if (u != 2 && u != 3 && u != 16 && u != 17 && u != 18 && u != 20 && u != 21) begin
        issue(6'(u));
        chk("R11 no done", {31'd0, done}, 32'd0);
        chk("R11 no req", {31'd0, memReq}, 32'd0);
      end
    end

    // R11: start during an open access is ignored
    spIn = 16'h3000; pcIn = 16'h0100; immIn = 16'h0200;
    issue(6'b010000);
    condMask = 3'b000; condPol = 3'b000;
    issue(6'b000010);
    chk("R11 busy no done", {31'd0, done}, 32'd0);
    chk("R11 busy addr", {16'd0, memAddr}, {16'd0, 16'h2FFE});
    ackAfter(0, 1'b0, 16'h0, 16'h2FFE, 1'b1);
    chk("R11 call result", {16'd0, pcNext}, {16'd0, 16'h0200});
    @(negedge clk);
    chk("R11 single done", {31'd0, done}, 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule